// File: doc/BRIEF.md
# Low Pin Count I/O Target

This block sits on the peripheral side of a Low Pin Count bus and runs on the bus clock. It watches the active-low frame strobe and the four multiplexed address/data lines. It serves single-byte I/O read and I/O write cycles whose 16-bit address falls inside a window of 2^WIN_BITS bytes placed at BASE_ADDR. All other traffic is ignored.

A served cycle reaches the local register side through a small port. The port carries an address offset inside the window, write data, one-clock write and read strobes, read data and a ready input. The block inserts long-wait sync codes until the local side reports ready. For reads it then returns the byte as two nibbles. It handles the turnaround clocks at both ends of the sync phase.

The data lines are split into an input, an output and an output enable, so the pad buffer can sit outside the block. The frame strobe has priority over everything. Once it is seen low, the block releases the lines on the next clock and begins decoding again.

Top module: `lpc_io_target`

## Requirements
- R1: A cycle starts only when the frame strobe is sampled low with the data lines at 0000. While the strobe stays low, the last nibble sampled decides whether a cycle starts. Any other nibble sampled with the strobe low leaves the block idle.
- R2: The first nibble after the start is the type. Values 0000 and 0001 mean I/O read, and 0010 and 0011 mean I/O write. Any other type is ignored: the lines are never driven and no local strobe fires until the next start.
- R3: The 16-bit address follows as four nibbles, most significant first. A cycle is served only when address bits [15:WIN_BITS] equal the same bits of BASE_ADDR. On a miss there is no drive and no strobe. loc_addr gives address bits [WIN_BITS-1:0].
- R4: For writes, two data nibbles follow the address, low nibble first. loc_wr pulses for exactly one clock, in the clock after the high nibble is sampled. During that pulse loc_addr and loc_wdata are valid.
- R5: After two host turnaround clocks, the block drives 0110 for at least one clock. It keeps driving 0110 as long as loc_ready is sampled low. In the clock after loc_ready is sampled high it drives 0000.
- R6: For reads, loc_rd pulses for one clock in the first 0110 clock. loc_rdata is captured at the same edge that samples loc_ready high. After the 0000 code, the byte is driven low nibble first and then high nibble.
- R7: After the 0000 code (writes) or the high data nibble (reads), the block drives 1111 for one clock and then releases the lines.
- R8: If the frame strobe is sampled low in any phase, lad_oe is low from the next clock and decoding restarts under R1.
- R9: A synchronous active-low reset returns the block to idle, with lad_oe, loc_wr and loc_rd low from the clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Data lines as seen at the pad |
| lad_out | output | 4 | Nibble driven when lad_oe is high |
| lad_oe | output | 1 | Drive enable for the data lines |
| loc_addr | output | WIN_BITS | Offset of the access inside the window |
| loc_wdata | output | 8 | Write byte for the local side |
| loc_wr | output | 1 | One-clock local write strobe |
| loc_rd | output | 1 | One-clock local read strobe |
| loc_rdata | input | 8 | Read byte from the local side |
| loc_ready | input | 1 | Local side has finished the access |

## Verification
The state machine drives every output directly, so a wrong phase shows on the ports within one clock. It appears as a sync or data nibble in the wrong clock, or as lad_oe high in a clock where the host owns the lines. A miscounted nibble counter shifts the address or data by one position, which shows as a wrong loc_addr or loc_wdata at the write pulse or as swapped read nibbles. A stale state after a frame abort or a window miss shows as a drive or strobe in a clock where the lines should stay quiet.

// File: rtl/lpc_io_target.sv
module lpc_io_target #(
  parameter logic [15:0] BASE_ADDR = 16'h0480,
  parameter int          WIN_BITS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic [3:0]          lad_in,
  output logic [3:0]          lad_out,
  output logic                lad_oe,
  output logic [WIN_BITS-1:0] loc_addr,
  output logic [7:0]          loc_wdata,
  output logic                loc_wr,
  output logic                loc_rd,
  input  logic [7:0]          loc_rdata,
  input  logic                loc_ready
);

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_WAIT  = 4'b0110;
  localparam logic [3:0] NIB_OK    = 4'b0000;
  localparam logic [3:0] NIB_TAR   = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_TYPE, S_ADDR, S_WDAT, S_HTAR, S_SWAIT, S_SOK, S_RDAT, S_TEND
  } st_t;

  st_t        state;
  logic [1:0] cnt;
  logic       is_wr;
  logic [11:0] addr_q;
  logic [7:0] wdat_q;
  logic [7:0] rdat_q;

  wire [15:0] addr_full = {addr_q, lad_in};
  wire        hit = (addr_full[15:WIN_BITS] == BASE_ADDR[15:WIN_BITS]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      is_wr  <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else if (!frame_n) begin
      state <= (lad_in == NIB_START) ? S_TYPE : S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_TYPE: begin
          cnt <= '0;
          if (lad_in[3:2] == 2'b00) begin
            is_wr <= lad_in[1];
            state <= S_ADDR;
          end else begin
            state <= S_IDLE;
          end
        end
        S_ADDR: begin
          addr_q <= addr_full[11:0];
          cnt    <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            cnt   <= '0;
            state <= !hit ? S_IDLE : (is_wr ? S_WDAT : S_HTAR);
          end
        end
        S_WDAT: begin
          if (cnt == 2'd0) begin
            wdat_q[3:0] <= lad_in;
            cnt         <= 2'd1;
          end else begin
            wdat_q[7:4] <= lad_in;
            cnt         <= '0;
            state       <= S_HTAR;
          end
        end
        S_HTAR: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) begin
            cnt   <= '0;
            state <= S_SWAIT;
          end
        end
        S_SWAIT: begin
          cnt <= 2'd1;
          if (loc_ready) begin
            rdat_q <= loc_rdata;
            cnt    <= '0;
            state  <= S_SOK;
          end
        end
        S_SOK: begin
          cnt   <= '0;
          state <= is_wr ? S_TEND : S_RDAT;
        end
        S_RDAT: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) begin
            cnt   <= '0;
            state <= S_TEND;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign lad_oe    = (state == S_SWAIT) || (state == S_SOK) ||
                     (state == S_RDAT)  || (state == S_TEND);
  assign loc_wr    = (state == S_HTAR) && (cnt == 2'd0) && is_wr;
  assign loc_rd    = (state == S_SWAIT) && (cnt == 2'd0) && !is_wr;
  assign loc_addr  = addr_q[WIN_BITS-1:0];
  assign loc_wdata = wdat_q;

  always_comb begin
    case (state)
      S_SWAIT: lad_out = NIB_WAIT;
      S_SOK:   lad_out = NIB_OK;
      S_RDAT:  lad_out = (cnt == 2'd0) ? rdat_q[3:0] : rdat_q[7:4];
      S_TEND:  lad_out = NIB_TAR;
      default: lad_out = 4'h0;
    endcase
  end

  // R8
  frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  // R4
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr |=> !loc_wr);

  // R6
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rd |=> !loc_rd);

  // R5
  first_drive_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> (lad_out == NIB_WAIT));

  // R5
  ready_code_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SOK) |-> $past(loc_ready));

  // R7
  tar_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TEND) |=> !lad_oe);

endmodule

// File: tb/lpc_io_target_tb_top.sv
module lpc_io_target_tb_top;
  localparam logic [15:0] BASE = 16'h0480;
  localparam int          WB   = 4;

  logic          clk = 1'b0;
  logic          rst_n, frame_n, lad_oe, loc_wr, loc_rd, loc_ready;
  logic [3:0]    lad_in, lad_out;
  logic [WB-1:0] loc_addr;
  logic [7:0]    loc_wdata, loc_rdata;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lpc_io_target #(.BASE_ADDR(BASE), .WIN_BITS(WB)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_wr(loc_wr), .loc_rd(loc_rd),
    .loc_rdata(loc_rdata), .loc_ready(loc_ready));

  function automatic bit in_win(logic [15:0] a);
    return a[15:WB] == BASE[15:WB];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive inputs at the current negedge, then move to the next negedge
  task automatic drive(bit f, logic [3:0] n);
    frame_n = f;
    lad_in  = n;
    @(negedge clk);
  endtask

  task automatic obs(bit eo, logic [3:0] el, bit ew, bit er, string req);
    logic [6:0] act, exp;
    act = {lad_oe, lad_oe ? lad_out : 4'h0, loc_wr, loc_rd};
    exp = {eo, eo ? el : 4'h0, ew, er};
    chk(act == exp, req, "{oe,lad,wr,rd}", int'(act), int'(exp));
  endtask

  // abort_k: sync clock index at which to abort; kind 1 = frame, 2 = reset
  task automatic run_io(bit w, logic [15:0] addr, logic [7:0] wd, logic [7:0] rd,
                        int waitn, int abort_k, int kind);
    bit hit = in_win(addr);
    string rq = hit ? "R5" : "R3";
    drive(0, 4'h0);
    obs(0, 0, 0, 0, "R1");
    drive(1, {2'b00, w, 1'($urandom % 2)});
    obs(0, 0, 0, 0, "R2");
    for (int i = 3; i >= 0; i--) begin
      drive(1, addr[4*i +: 4]);
      obs(0, 0, 0, 0, "R3");
    end
    if (w) begin
      drive(1, wd[3:0]);
      obs(0, 0, 0, 0, "R4");
      drive(1, wd[7:4]);
      obs(0, 0, hit, 0, hit ? "R4" : "R3");
      if (hit) begin
        chk(loc_wdata == wd, "R4", "loc_wdata", int'(loc_wdata), int'(wd));
        chk(loc_addr == addr[WB-1:0], "R3", "loc_addr", int'(loc_addr), int'(addr[WB-1:0]));
      end
    end
    drive(1, 4'hF);
    obs(0, 0, 0, 0, rq);
    drive(1, 4'hF);
    for (int k = 0; k <= waitn; k++) begin
      obs(hit, 4'b0110, 0, hit && !w && k == 0, hit ? (w ? "R5" : "R6") : "R3");
      if (k == abort_k) begin
        loc_ready = 1'b0;
        if (kind == 2) begin
          rst_n = 1'b0;
          drive(1, 4'hF);
          obs(0, 0, 0, 0, "R9");
          rst_n = 1'b1;
        end else begin
          drive(0, 4'hF);
          obs(0, 0, 0, 0, "R8");
        end
        return;
      end
      if (k == 0 && hit && !w)
        chk(loc_addr == addr[WB-1:0], "R3", "loc_addr", int'(loc_addr), int'(addr[WB-1:0]));
      loc_ready = (k == waitn);
      loc_rdata = rd;
      drive(1, 4'hF);
    end
    obs(hit, 4'b0000, 0, 0, rq);
    loc_ready = 1'b0;
    loc_rdata = 8'($urandom);
    drive(1, 4'hF);
    if (!w) begin
      obs(hit, rd[3:0], 0, 0, hit ? "R6" : "R3");
      drive(1, 4'hF);
      obs(hit, rd[7:4], 0, 0, hit ? "R6" : "R3");
      drive(1, 4'hF);
    end
    obs(hit, 4'hF, 0, 0, hit ? "R7" : "R3");
    drive(1, 4'hF);
    obs(0, 0, 0, 0, hit ? "R7" : "R3");
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; frame_n = 1'b1; lad_in = 4'hF; loc_ready = 1'b0; loc_rdata = 8'h00;
    @(negedge clk);
    drive(1, 4'hF);
    drive(1, 4'hF);
    obs(0, 0, 0, 0, "R9");
    rst_n = 1'b1;
    drive(1, 4'hF);
    obs(0, 0, 0, 0, "R9");

    // directed: window edges, both directions
    run_io(1, BASE,          8'hA5, 8'h00, 0, -1, 0);
    run_io(0, BASE + 16'd15, 8'h00, 8'h3C, 0, -1, 0);
    run_io(0, BASE - 16'd1,  8'h00, 8'h77, 1, -1, 0);
    run_io(1, BASE + 16'd16, 8'h12, 8'h00, 1, -1, 0);
    run_io(0, BASE + 16'd7,  8'h00, 8'hF0, 5, -1, 0);

    // R2: unsupported cycle types are never answered
    for (int t = 4; t < 16; t += 3) begin
      drive(0, 4'h0);
      drive(1, 4'(t));
      for (int i = 0; i < 12; i++) begin
        obs(0, 0, 0, 0, "R2");
        loc_ready = 1'b1;
        drive(1, (i < 4) ? BASE[4*(3-i) +: 4] : 4'hF);
      end
      loc_ready = 1'b0;
      obs(0, 0, 0, 0, "R2");
    end

    // R1: frame low with a non-start nibble starts nothing
    drive(0, 4'h3);
    drive(1, 4'h0);
    for (int i = 3; i >= 0; i--) drive(1, BASE[4*i +: 4]);
    for (int i = 0; i < 6; i++) begin
      obs(0, 0, 0, 0, "R1");
      loc_ready = 1'b1;
      drive(1, 4'hF);
    end
    loc_ready = 1'b0;

    // R1: long frame, last nibble counts
    drive(0, 4'hF);
    drive(0, 4'h9);
    run_io(0, BASE + 16'd2, 8'h00, 8'h5A, 0, -1, 0);

    // R8: restart in mid address, then abort during sync
    drive(0, 4'h0);
    drive(1, 4'h2);
    drive(1, 4'h0);
    drive(1, 4'h4);
    run_io(1, BASE + 16'd9, 8'hC3, 8'h00, 2, -1, 0);
    run_io(0, BASE + 16'd1, 8'h00, 8'h11, 4, 2, 1);
    run_io(1, BASE + 16'd4, 8'h66, 8'h00, 0, -1, 0);

    // R9: reset while driving
    run_io(0, BASE + 16'd3, 8'h00, 8'h99, 3, 1, 2);
    run_io(0, BASE + 16'd3, 8'h00, 8'h81, 0, -1, 0);

    // random traffic
    for (int n = 0; n < 80; n++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? (BASE + 16'($urandom % 16)) : 16'($urandom);
      run_io(1'($urandom % 2), a, 8'($urandom), 8'($urandom), int'($urandom % 5), -1, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule